// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front end of a compact processor core whose instructions are one or two 16-bit words. It keeps a byte-addressed program counter and drives a word address into a synchronous instruction memory that answers one cycle later. From the words that come back it delivers one executed instruction at a time. A one-word instruction is delivered on its own. The two words of a jump, a call or a register-to-register move are joined into a single 32-bit instruction. Continuation words that are reached without their leading word, and words cancelled by a taken skip, are delivered as NOPs.

The sequencer applies control flow to its own counter. An absolute jump or call loads a 20-bit word target. A relative branch adds a signed displacement counted in words. A skip instruction, whose condition comes from the execution stage on `skip_cond`, cancels the next word. The block does not execute the delivered operations. It has no call stack. It does not take interrupts. A call is treated as a jump.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `fetch_pc` = 0 and `instr_valid` = 0. Any half-assembled pair and any pending skip are discarded.
- R2: `imem_addr` always equals `fetch_pc` shifted right by one, and bit 0 of `fetch_pc` is always 0. Each word that does not change flow advances `fetch_pc` by 2.
- R3: A one-word instruction is delivered as `instr` = {word, 16'h0000} with `is_nop` = 0. `instr_valid` is never high in two consecutive cycles.
- R4: A first word 0xEF followed by any word forms a jump. It is delivered as `instr` = {first, second}. `fetch_pc` becomes {second[11:0], first[7:0], 0}, so 0xEF03, 0xF000 lands on byte 0x0006.
- R5: A first word whose top seven bits are 1110110 (0xEC or 0xED) forms a call. Its target is computed and delivered exactly as for the jump in R4.
- R6: A first word whose top nibble is 0xC forms a move. The word after it is always used as its second word, for example 0xC123, 0xF456. The pair is delivered as one instruction, and `fetch_pc` then moves on by 2 from the second word.
- R7: A word whose top nibble is 0xF, reached when no first word is pending, is delivered as `instr` = {word, 16'h0000} with `is_nop` = 1. Its only effect is the advance of R2.
- R8: A skip word (top seven bits 0110011) executed while `skip_cond` = 1 causes the next word to be delivered as a NOP with `instr` = {word, 16'h0000}. If that word was a first word, the continuation word after it is also delivered as a NOP.
- R9: A skip word executed while `skip_cond` = 0 has no effect on the words after it.
- R10: A branch word 0xE0nn sets `fetch_pc` to its own address + 2 + 2 × nn, where nn is read as a signed 8-bit value.
- R11: While `stall` is high, `fetch_pc` and all internal state hold, and `instr_valid` is 0 in the following cycle. The delivered sequence is the same as without the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze request from later stages |
| skip_cond | input | 1 | Outcome of the skip test for the skip word now being decoded |
| imem_addr | output | 20 | Word address to the synchronous instruction memory |
| imem_rdata | input | 16 | Word read back one cycle after `imem_addr` |
| instr_valid | output | 1 | One-cycle pulse for each executed instruction |
| instr | output | 32 | Delivered instruction: a pair, or {word, 16'h0000} |
| is_nop | output | 1 | The delivered instruction must act as a NOP |
| fetch_pc | output | 21 | Byte program counter |

## Verification
The hardest case is a skip that lands on the first word of a move. Two NOPs must then come out in a row, and the continuation word must not be joined with anything. That depends on both the skip condition and the word layout. The stimulus places a skip word directly in front of a move pair and replays the same program with `skip_cond` held high and then held low. The full sequence of delivered instructions is compared in both runs. A stall is also raised while a word is in flight, to show the pairing state survives the freeze.

// File: rtl/fseq_pkg.sv
// Package fseq_pkg
// Shared types and encodings for the two-word fetch sequencer.
// Assumes 16-bit instruction words; continuation words carry a 4-bit prefix.
package fseq_pkg;

    localparam int WORD_W = 16;
    localparam int PAIR_W = 2 * WORD_W;
    localparam int HI_W   = 8;   // opcode byte examined by the classifier
    localparam int OFF_W  = 8;   // relative branch offset width
    localparam int LIT_W  = 12;  // literal field of a continuation word

    localparam logic [3:0] CONT_NIB    = 4'hF;
    localparam logic [3:0] MOVE_NIB    = 4'hC;
    localparam logic [7:0] GOTO_BYTE   = 8'hEF;
    localparam logic [6:0] CALL_HI7    = 7'b1110110;
    localparam logic [7:0] BRANCH_BYTE = 8'hE0;
    localparam logic [6:0] SKIP_HI7    = 7'b0110011;

    typedef enum logic [2:0] {
        WK_PLAIN,
        WK_CONT,
        WK_MOVE,
        WK_GOTO,
        WK_CALL,
        WK_BRANCH,
        WK_SKIP
    } word_kind_e;

    typedef enum logic [1:0] {
        PC_SEQ,
        PC_JUMP,
        PC_BRANCH
    } pc_sel_e;

    typedef enum logic {
        PH_ADDR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              emit;
        logic              nop;
        logic [PAIR_W-1:0] word_pair;
        pc_sel_e           pc_sel;
        logic              pend_set;
        logic              pend_clr;
        logic              skip_arm;
        logic              skip_clr;
    } step_t;

endpackage

// File: rtl/fseq_classify.sv
// Module fseq_classify
// Sorts a fetched word into a kind using its top byte only.
// Assumes the caller applies pairing and skip context; this is context-free.
module fseq_classify
    import fseq_pkg::*;
(
    input  logic [HI_W-1:0] word_hi,
    output word_kind_e      kind
);

    // Priority decode of the opcode byte into a word kind.
    always_comb begin
        if (word_hi[7:4] == CONT_NIB) begin
            kind = WK_CONT;
        end else if (word_hi[7:4] == MOVE_NIB) begin
            kind = WK_MOVE;
        end else if (word_hi == GOTO_BYTE) begin
            kind = WK_GOTO;
        end else if (word_hi[7:1] == CALL_HI7) begin
            kind = WK_CALL;
        end else if (word_hi == BRANCH_BYTE) begin
            kind = WK_BRANCH;
        end else if (word_hi[7:1] == SKIP_HI7) begin
            kind = WK_SKIP;
        end else begin
            kind = WK_PLAIN;
        end
    end

endmodule

// File: rtl/fseq_step.sv
// Module fseq_step
// Decides what one fetched word does, given the pairing and skip context:
// whether an instruction is delivered, whether it is a NOP, how the PC moves,
// and how the pending-pair and skip-armed flags change.
// Assumes it is consulted only in the cycle the memory word is valid.
module fseq_step
    import fseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  word_kind_e        kind,
    input  logic              pend_valid,
    input  logic              pend_jump,
    input  logic [WORD_W-1:0] pend_word,
    input  logic              skip_armed,
    input  logic              skip_cond,
    output step_t             st
);

    localparam logic [WORD_W-1:0] ZERO_WORD = '0;

    // Context-dependent action for the current word.
    always_comb begin
        st        = '0;
        st.pc_sel = PC_SEQ;
        if (skip_armed) begin
            // Cancelled word: delivered as NOP, never starts a pair.
            st.emit      = 1'b1;
            st.nop       = 1'b1;
            st.word_pair = {word, ZERO_WORD};
            st.skip_clr  = 1'b1;
        end else if (pend_valid) begin
            // Second half of a pair: join and apply the flow change.
            st.emit      = 1'b1;
            st.word_pair = {pend_word, word};
            st.pend_clr  = 1'b1;
            if (pend_jump) begin
                st.pc_sel = PC_JUMP;
            end
        end else begin
            case (kind)
                WK_CONT: begin
                    st.emit      = 1'b1;
                    st.nop       = 1'b1;
                    st.word_pair = {word, ZERO_WORD};
                end
                WK_MOVE, WK_GOTO, WK_CALL: begin
                    st.pend_set = 1'b1;
                end
                WK_BRANCH: begin
                    st.emit      = 1'b1;
                    st.word_pair = {word, ZERO_WORD};
                    st.pc_sel    = PC_BRANCH;
                end
                WK_SKIP: begin
                    st.emit      = 1'b1;
                    st.word_pair = {word, ZERO_WORD};
                    st.skip_arm  = skip_cond;
                end
                default: begin
                    st.emit      = 1'b1;
                    st.word_pair = {word, ZERO_WORD};
                end
            endcase
        end
    end

endmodule

// File: rtl/fseq_target.sv
// Module fseq_target
// Computes the next byte PC: sequential (+2), absolute word target, or
// relative branch counted in words from the following instruction.
// Assumes PC_W >= 21 so a 20-bit word target fits above bit 0.
module fseq_target
    import fseq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [PC_W-1:0]  pc,
    input  pc_sel_e          sel,
    input  logic [7:0]       jump_lo,
    input  logic [LIT_W-1:0] jump_hi,
    input  logic [OFF_W-1:0] br_off,
    output logic [PC_W-1:0]  pc_next
);

    localparam int EXT_W = PC_W - OFF_W - 1;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;
    logic [PC_W-1:0] disp;

    // Candidate addresses; bit 0 is zero in every one of them.
    always_comb begin
        seq_pc  = pc + PC_W'(2);
        jump_pc = PC_W'({jump_hi, jump_lo, 1'b0});
        disp    = {{EXT_W{br_off[OFF_W-1]}}, br_off, 1'b0};
    end

    // Selection of the next PC.
    always_comb begin
        case (sel)
            PC_JUMP:   pc_next = jump_pc;
            PC_BRANCH: pc_next = seq_pc + disp;
            default:   pc_next = seq_pc;
        endcase
    end

endmodule

// File: rtl/fetch_sequencer.sv
// Module fetch_sequencer
// Program counter and fetch front end for 16-bit instruction words, some of
// which pair into 32-bit instructions. Works in two phases per word: address
// out, then data back from a one-cycle synchronous memory. Delivers at most
// one instruction every two cycles on registered outputs.
// Assumes the memory returns the word for imem_addr one cycle later and keeps
// returning it while the address is held.
module fetch_sequencer
    import fseq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              skip_cond,
    output logic [PC_W-2:0]   imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              instr_valid,
    output logic [PAIR_W-1:0] instr,
    output logic              is_nop,
    output logic [PC_W-1:0]   fetch_pc
);

    phase_e            phase;
    logic              pend_valid;
    logic              pend_jump;
    logic [WORD_W-1:0] pend_word;
    logic              skip_armed;
    word_kind_e        kind;
    step_t             st;
    logic [PC_W-1:0]   pc_next;
    logic              advance;

    assign imem_addr = fetch_pc[PC_W-1:1];
    assign advance   = !stall && (phase == PH_DATA);

    fseq_classify u_classify (
        .word_hi (imem_rdata[WORD_W-1:WORD_W-HI_W]),
        .kind    (kind)
    );

    fseq_step u_step (
        .word       (imem_rdata),
        .kind       (kind),
        .pend_valid (pend_valid),
        .pend_jump  (pend_jump),
        .pend_word  (pend_word),
        .skip_armed (skip_armed),
        .skip_cond  (skip_cond),
        .st         (st)
    );

    fseq_target #(.PC_W(PC_W)) u_target (
        .pc      (fetch_pc),
        .sel     (st.pc_sel),
        .jump_lo (pend_word[7:0]),
        .jump_hi (imem_rdata[LIT_W-1:0]),
        .br_off  (imem_rdata[OFF_W-1:0]),
        .pc_next (pc_next)
    );

    // Phase toggle and program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_ADDR;
            fetch_pc <= '0;
        end else if (!stall) begin
            if (phase == PH_ADDR) begin
                phase <= PH_DATA;
            end else begin
                phase    <= PH_ADDR;
                fetch_pc <= pc_next;
            end
        end
    end

    // Holding register for the first word of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_jump  <= 1'b0;
            pend_word  <= '0;
        end else if (advance) begin
            if (st.pend_set) begin
                pend_valid <= 1'b1;
                pend_word  <= imem_rdata;
                pend_jump  <= (kind == WK_GOTO) || (kind == WK_CALL);
            end else if (st.pend_clr) begin
                pend_valid <= 1'b0;
            end
        end
    end

    // Skip flag: cancels the next word after a taken skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_armed <= 1'b0;
        end else if (advance) begin
            if (st.skip_arm) begin
                skip_armed <= 1'b1;
            end else if (st.skip_clr) begin
                skip_armed <= 1'b0;
            end
        end
    end

    // Registered delivery of executed instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_valid <= 1'b0;
            instr       <= '0;
            is_nop      <= 1'b0;
        end else begin
            instr_valid <= advance && st.emit;
            if (advance && st.emit) begin
                instr  <= st.word_pair;
                is_nop <= st.nop;
            end
        end
    end

    // ---------------- assertions ----------------

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc == '0) && !instr_valid)
        else $error("R1: state after reset");

    assert_pc_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pc[0] == 1'b0)
        else $error("R2: odd program counter");

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid)
        else $error("R3: back-to-back delivery");

    assert_goto_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_nop && instr[31:24] == GOTO_BYTE)
        |-> fetch_pc == PC_W'({instr[11:0], instr[23:16], 1'b0}))
        else $error("R4: jump target");

    assert_call_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_nop && instr[31:25] == CALL_HI7)
        |-> fetch_pc == PC_W'({instr[11:0], instr[23:16], 1'b0}))
        else $error("R5: call target");

    assert_move_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_nop && instr[31:28] == MOVE_NIB)
        |-> fetch_pc == $past(fetch_pc) + PC_W'(2))
        else $error("R6: move does not continue sequentially");

    assert_lone_cont_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[31:28] == CONT_NIB) |-> is_nop)
        else $error("R7: lone continuation not a NOP");

    assert_branch_disp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_nop && instr[31:24] == BRANCH_BYTE)
        |-> fetch_pc == $past(fetch_pc) + PC_W'(2)
                        + {{(PC_W-OFF_W-1){instr[23]}}, instr[23:16], 1'b0})
        else $error("R10: branch displacement");

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(fetch_pc) && !instr_valid)
        else $error("R11: state moved under stall");

endmodule

// File: tb/fetch_sequencer_bench.sv
module fetch_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        skip_cond = 1'b0;
    logic [19:0] imem_addr;
    logic [15:0] imem_rdata;
    logic        instr_valid;
    logic [31:0] instr;
    logic        is_nop;
    logic [20:0] fetch_pc;

    int checks = 0;
    int fails  = 0;

    logic [15:0] rom [0:15];
    logic [31:0] log_instr [0:63];
    logic        log_nop   [0:63];
    int          n_log = 0;
    int          dbl = 0;
    logic        prev_valid = 1'b0;

    always #4 clk = ~clk;

    fetch_sequencer u_fetch_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .skip_cond   (skip_cond),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .instr_valid (instr_valid),
        .instr       (instr),
        .is_nop      (is_nop),
        .fetch_pc    (fetch_pc)
    );

    // Synchronous instruction memory, one cycle of latency.
    always @(posedge clk) imem_rdata <= rom[imem_addr[3:0]];

    // Capture of every delivered instruction, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && instr_valid) begin
            if (n_log < 64) begin
                log_instr[n_log] = instr;
                log_nop[n_log]   = is_nop;
            end
            n_log = n_log + 1;
            if (prev_valid) dbl = dbl + 1;
        end
        prev_valid = rst_n && instr_valid;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_item(input int idx, input logic [31:0] ins,
                               input logic nop, input string req);
        check(idx < n_log, req, 32'(n_log), 32'(idx + 1));
        if (idx < n_log) begin
            check(log_instr[idx] === ins, req, log_instr[idx], ins);
            check(log_nop[idx] === nop, req, 32'(log_nop[idx]), 32'(nop));
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 16; i++) rom[i] = 16'hE0FF;
    endtask

    task automatic run_prog(input logic cond, input int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        stall = 1'b0;
        skip_cond = cond;
        repeat (2) @(negedge clk);
        n_log = 0;
        dbl = 0;
        rst_n = 1'b1;
        repeat (ncyc) @(negedge clk);
    endtask

    // R2 R3 R7: plain word, lone continuation, then self-branch.
    task automatic test_plain_cont();
        clear_rom();
        rom[0] = 16'h0E55;
        rom[1] = 16'hF123;
        run_prog(1'b0, 20);
        expect_item(0, 32'h0E55_0000, 1'b0, "R3");
        expect_item(1, 32'hF123_0000, 1'b1, "R7");
        expect_item(2, 32'hE0FF_0000, 1'b0, "R10");
        check(fetch_pc == 21'h4, "R2", 32'(fetch_pc), 32'h4);
        check(imem_addr == 20'h2, "R2", 32'(imem_addr), 32'h2);
        check(dbl == 0, "R3", 32'(dbl), 32'h0);
    endtask

    // R4: 0xEF03 0xF000 jumps to byte 6.
    task automatic test_goto();
        clear_rom();
        rom[0] = 16'hEF03;
        rom[1] = 16'hF000;
        rom[2] = 16'h1111;
        run_prog(1'b0, 20);
        expect_item(0, 32'hEF03_F000, 1'b0, "R4");
        expect_item(1, 32'hE0FF_0000, 1'b0, "R4");
        check(fetch_pc == 21'h6, "R4", 32'(fetch_pc), 32'h6);
        check(imem_addr == 20'h3, "R2", 32'(imem_addr), 32'h3);
    endtask

    // R1: reset from a non-zero PC.
    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(fetch_pc == 21'h0, "R1", 32'(fetch_pc), 32'h0);
        check(instr_valid == 1'b0, "R1", 32'(instr_valid), 32'h0);
        check(imem_addr == 20'h0, "R1", 32'(imem_addr), 32'h0);
    endtask

    // R5: call 0xEC04 0xF000 lands on byte 8.
    task automatic test_call();
        clear_rom();
        rom[0] = 16'hEC04;
        rom[1] = 16'hF000;
        rom[2] = 16'h2222;
        run_prog(1'b0, 20);
        expect_item(0, 32'hEC04_F000, 1'b0, "R5");
        check(fetch_pc == 21'h8, "R5", 32'(fetch_pc), 32'h8);
    endtask

    // R6: move pair joined, PC continues sequentially.
    task automatic test_move();
        clear_rom();
        rom[0] = 16'hC123;
        rom[1] = 16'hF456;
        run_prog(1'b0, 20);
        expect_item(0, 32'hC123_F456, 1'b0, "R6");
        expect_item(1, 32'hE0FF_0000, 1'b0, "R6");
        check(fetch_pc == 21'h4, "R6", 32'(fetch_pc), 32'h4);
    endtask

    // R8: taken skip ahead of a move; both halves become NOPs.
    task automatic test_skip_taken();
        clear_rom();
        rom[0] = 16'h6600;
        rom[1] = 16'hC123;
        rom[2] = 16'hF456;
        run_prog(1'b1, 30);
        expect_item(0, 32'h6600_0000, 1'b0, "R8");
        expect_item(1, 32'hC123_0000, 1'b1, "R8");
        expect_item(2, 32'hF456_0000, 1'b1, "R8");
        expect_item(3, 32'hE0FF_0000, 1'b0, "R8");
        check(fetch_pc == 21'h6, "R8", 32'(fetch_pc), 32'h6);
    endtask

    // R9: skip not taken ahead of the same move.
    task automatic test_skip_not_taken();
        clear_rom();
        rom[0] = 16'h6600;
        rom[1] = 16'hC123;
        rom[2] = 16'hF456;
        run_prog(1'b0, 30);
        expect_item(0, 32'h6600_0000, 1'b0, "R9");
        expect_item(1, 32'hC123_F456, 1'b0, "R9");
        expect_item(2, 32'hE0FF_0000, 1'b0, "R9");
        check(fetch_pc == 21'h6, "R9", 32'(fetch_pc), 32'h6);
    endtask

    // R10: forward branch +3 words, then backward -3 words, then self loop.
    task automatic test_branch();
        clear_rom();
        rom[0] = 16'hE003;
        rom[4] = 16'hE0FD;
        run_prog(1'b0, 20);
        expect_item(0, 32'hE003_0000, 1'b0, "R10");
        expect_item(1, 32'hE0FD_0000, 1'b0, "R10");
        expect_item(2, 32'hE0FF_0000, 1'b0, "R10");
        check(fetch_pc == 21'h4, "R10", 32'(fetch_pc), 32'h4);
    endtask

    // R11: stall while a move's first word is pending.
    task automatic test_stall();
        logic [20:0] held;
        clear_rom();
        rom[0] = 16'hC123;
        rom[1] = 16'hF456;
        @(negedge clk);
        rst_n = 1'b0;
        skip_cond = 1'b0;
        repeat (2) @(negedge clk);
        n_log = 0;
        dbl = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        stall = 1'b1;
        held = fetch_pc;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(fetch_pc == held, "R11", 32'(fetch_pc), 32'(held));
            check(instr_valid == 1'b0, "R11", 32'(instr_valid), 32'h0);
        end
        stall = 1'b0;
        repeat (12) @(negedge clk);
        expect_item(0, 32'hC123_F456, 1'b0, "R11");
        expect_item(1, 32'hE0FF_0000, 1'b0, "R11");
        check(fetch_pc == 21'h4, "R11", 32'(fetch_pc), 32'h4);
    endtask

    initial begin
        clear_rom();
        test_plain_cont();
        test_goto();
        test_reset();
        test_call();
        test_move();
        test_skip_taken();
        test_skip_not_taken();
        test_branch();
        test_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule